// File: doc/BRIEF.md
# Latchable Channel Selector with Dead-Time Switching

This block is the digital control for a bank of eight analog switches. It takes a channel address, an enable bit and two active-low strobes (write and clear). It drives one enable line per switch. While write is low the address and enable pass straight into the selection. When write rises, the selection is frozen until write drops again or clear is pulled low. A latched enable of zero turns every switch off, so that several banks can share one output node and form a wider selector.

A parameter selects a paired arrangement. In that arrangement a 2-bit address picks one of four pairs. Pair k drives outputs k and k+4 together. Any change of the closed switch first opens everything and then waits a programmable number of clock cycles before the new switch closes. Turn-off never waits. The strobes are synchronized to the system clock. After power-up or a system reset, the block keeps every switch open until it has seen a clear pulse of a minimum length.

Top module: `chan_sel_bbm`

## Requirements
- R1: With clear high and write low, the latched address and enable track `addr_i`/`en_i`, and the matching switch closes once the dead interval has run out.
- R2: After write rises, changes on `addr_i` and `en_i` leave `sw_o` unchanged until write returns low.
- R3: While clear is low, all outputs are off and the latched enable is cleared. If clear is released with write high, all outputs stay off.
- R4: A latched enable of 0 holds every output off.
- R5: In single mode (PAIRED=0), address value k (0 to 7) drives only bit k of `sw_o`. Address 0 is the first channel.
- R6: In paired mode (PAIRED=1), address value k (0 to 3) drives bits k and k+4 of `sw_o` together.
- R7: When the selection changes to a new non-empty target, `sw_o` is all zero in the next cycle. The new value appears DEAD_CYC+2 clock edges after the latch takes the new value. `sw_o` never changes directly from one non-zero value to a different non-zero value.
- R8: A new selection that arrives during the dead interval restarts the interval. The superseded selection never closes.
- R9: An empty target (enable 0 or clear) opens all switches on the clock edge after the latch changes, without a dead interval.
- R10: After reset, all outputs stay off until the synchronized clear has been low for MIN_CLR consecutive cycles. A shorter pulse does not arm the block.
- R11: At no time is more than one channel (single mode) or more than one pair (paired mode) on.
- R12: The synchronous `rst` turns all outputs off at once and disarms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| addr_i | input | ADDR_W (3, or 2 when paired) | Channel or pair address |
| en_i | input | 1 | Enable bit, latched with the address |
| wr_n_i | input | 1 | Active-low write strobe: low is transparent, high holds |
| clr_n_i | input | 1 | Active-low clear strobe |
| sw_o | output | NUM_CH | Registered switch enables, one per switch |

## Verification
A corrupted latch shows up within DEAD_CYC+3 cycles as a wrong bit or a missing bit on `sw_o` after the held address is re-read. A dead-interval counter that is off by one moves the closing edge by one cycle. That error is visible only by sampling every cycle around a switchover, so the bench walks those cycles one at a time. A broken arming counter or synchronizer shows as outputs that close before a long enough clear pulse, or that never close after one. Overlapping switches would appear in the same cycle as an extra set bit, so a monitor watches every cycle.

// File: rtl/chan_sel_pkg.sv
package chan_sel_pkg;

  // width of a down-counter that must hold the value n
  function automatic int cnt_w(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // address width for the channel count and mode
  function automatic int addr_w(input int num_ch, input bit paired);
    int groups;
    groups = paired ? num_ch / 2 : num_ch;
    return (groups < 2) ? 1 : $clog2(groups);
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/sel_latch.sv
module sel_latch #(
  parameter int ADDR_W  = 3,
  parameter int MIN_CLR = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_s,
  input  logic              clr_s,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic [ADDR_W-1:0] held_addr,
  output logic              held_en,
  output logic              armed
);
  localparam int CW = chan_sel_pkg::cnt_w(MIN_CLR);

  logic [CW-1:0]     arm_cnt_q;
  logic              armed_q;
  logic [ADDR_W-1:0] addr_q;
  logic              en_q;

  // power-on arming: clear must be seen low for MIN_CLR consecutive cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      arm_cnt_q <= '0;
      armed_q   <= 1'b0;
    end else if (!armed_q) begin
      if (!clr_s) begin
        if (arm_cnt_q >= CW'(MIN_CLR - 1)) armed_q <= 1'b1;
        else                               arm_cnt_q <= arm_cnt_q + CW'(1);
      end else begin
        arm_cnt_q <= '0;
      end
    end
  end

  // level-sensitive capture, done as a clocked register
  always_ff @(posedge clk) begin
    if (rst || !armed_q || !clr_s) begin
      addr_q <= '0;
      en_q   <= 1'b0;
    end else if (!wr_s) begin
      addr_q <= addr_i;
      en_q   <= en_i;
    end
  end

  assign held_addr = addr_q;
  assign held_en   = en_q;
  assign armed     = armed_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (armed_q && clr_s && wr_s) |=> ({en_q, addr_q} == $past({en_q, addr_q})));

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr_s) |=> (!en_q && addr_q == '0));
endmodule

// File: rtl/sel_decode.sv
module sel_decode #(
  parameter int NUM_CH = 8,
  parameter bit PAIRED = 1'b0,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  output logic [NUM_CH-1:0] want
);
  localparam int HALF = NUM_CH / 2;

  generate
    if (PAIRED) begin : g_pair
      for (genvar k = 0; k < HALF; k++) begin : g_k
        assign want[k]        = en && (addr == ADDR_W'(k));
        assign want[k + HALF] = en && (addr == ADDR_W'(k));
      end
    end else begin : g_single
      for (genvar k = 0; k < NUM_CH; k++) begin : g_k
        assign want[k] = en && (addr == ADDR_W'(k));
      end
    end
  endgenerate
endmodule

// File: rtl/bbm_gate.sv
module bbm_gate #(
  parameter int NUM_CH   = 8,
  parameter bit PAIRED   = 1'b0,
  parameter int DEAD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] want,
  output logic [NUM_CH-1:0] sw
);
  localparam int GW   = chan_sel_pkg::cnt_w(DEAD_CYC);
  localparam int HALF = NUM_CH / 2;

  logic [NUM_CH-1:0] tgt_q, sw_q;
  logic [GW-1:0]     gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= '0;
      sw_q  <= '0;
      gap_q <= '0;
    end else begin
      tgt_q <= want;
      if (want == '0) begin
        sw_q  <= '0;
        gap_q <= '0;
      end else if (want != tgt_q) begin
        sw_q  <= '0;
        gap_q <= GW'(DEAD_CYC);
      end else if (gap_q != '0) begin
        gap_q <= gap_q - GW'(1);
      end else begin
        sw_q <= want;
      end
    end
  end

  assign sw = sw_q;

  p_off_next_r9: assert property (@(posedge clk) disable iff (rst)
    (want == '0) |=> (sw_q == '0));

  p_no_direct_r7: assert property (@(posedge clk) disable iff (rst)
    (sw_q != '0 && $past(sw_q) != '0) |-> (sw_q == $past(sw_q)));

  generate
    if (PAIRED) begin : g_chk_pair
      p_pair_r6: assert property (@(posedge clk) disable iff (rst)
        (sw_q[HALF-1:0] == sw_q[NUM_CH-1:HALF]) && $onehot0(sw_q[HALF-1:0]));
    end else begin : g_chk_single
      p_single_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sw_q));
    end
  endgenerate
endmodule

// File: rtl/chan_sel_bbm.sv
module chan_sel_bbm #(
  parameter int NUM_CH   = 8,
  parameter bit PAIRED   = 1'b0,
  parameter int DEAD_CYC = 4,
  parameter int MIN_CLR  = 3,
  localparam int ADDR_W  = chan_sel_pkg::addr_w(NUM_CH, PAIRED)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic              wr_n_i,
  input  logic              clr_n_i,
  output logic [NUM_CH-1:0] sw_o
);
  logic [1:0]        strb_s;
  logic [ADDR_W-1:0] held_addr;
  logic              held_en;
  logic              armed;
  logic [NUM_CH-1:0] want;

  strobe_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({clr_n_i, wr_n_i}),
    .q   (strb_s)
  );

  sel_latch #(.ADDR_W(ADDR_W), .MIN_CLR(MIN_CLR)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .wr_s      (strb_s[0]),
    .clr_s     (strb_s[1]),
    .addr_i    (addr_i),
    .en_i      (en_i),
    .held_addr (held_addr),
    .held_en   (held_en),
    .armed     (armed)
  );

  sel_decode #(.NUM_CH(NUM_CH), .PAIRED(PAIRED), .ADDR_W(ADDR_W)) u_dec (
    .addr (held_addr),
    .en   (held_en),
    .want (want)
  );

  bbm_gate #(.NUM_CH(NUM_CH), .PAIRED(PAIRED), .DEAD_CYC(DEAD_CYC)) u_gate (
    .clk  (clk),
    .rst  (rst),
    .want (want),
    .sw   (sw_o)
  );

  p_unarmed_off_r10: assert property (@(posedge clk) disable iff (rst)
    (!armed) |-> (sw_o == '0));
endmodule

// File: tb/chan_sel_bbm_tb_top.sv
`timescale 1ns/1ps
module chan_sel_bbm_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = 3'd3;
  logic       en = 1'b1, wr_n = 1'b0, clr_n = 1'b1;
  logic [7:0] sw, sw_p;
  int n_chk = 0, n_bad = 0, ovl = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chan_sel_bbm #(.PAIRED(1'b0)) dut_i (
    .clk(clk), .rst(rst), .addr_i(addr), .en_i(en),
    .wr_n_i(wr_n), .clr_n_i(clr_n), .sw_o(sw));

  chan_sel_bbm #(.PAIRED(1'b1)) dut_p_i (
    .clk(clk), .rst(rst), .addr_i(addr[1:0]), .en_i(en),
    .wr_n_i(wr_n), .clr_n_i(clr_n), .sw_o(sw_p));

  // {req[25:22], en[21], addr[20:18], wr_n[17], clr_n[16], exp[15:8], exp_pair[7:0]}
  localparam int NV = 13;
  localparam logic [25:0] VEC [NV] = '{
    {4'd1,  1'b1, 3'd1, 1'b0, 1'b1, 8'h02, 8'h22}, // R1 transparent
    {4'd2,  1'b1, 3'd1, 1'b1, 1'b1, 8'h02, 8'h22}, // R2 write rises
    {4'd2,  1'b1, 3'd6, 1'b1, 1'b1, 8'h02, 8'h22}, // R2 address ignored
    {4'd2,  1'b0, 3'd6, 1'b1, 1'b1, 8'h02, 8'h22}, // R2 enable ignored
    {4'd4,  1'b0, 3'd6, 1'b0, 1'b1, 8'h00, 8'h00}, // R4 enable 0
    {4'd5,  1'b1, 3'd6, 1'b0, 1'b1, 8'h40, 8'h44}, // R5
    {4'd5,  1'b1, 3'd0, 1'b0, 1'b1, 8'h01, 8'h11}, // R5 first channel
    {4'd6,  1'b1, 3'd7, 1'b0, 1'b1, 8'h80, 8'h88}, // R6 pair 3
    {4'd3,  1'b1, 3'd7, 1'b0, 1'b0, 8'h00, 8'h00}, // R3 clear low
    {4'd3,  1'b1, 3'd7, 1'b1, 1'b1, 8'h00, 8'h00}, // R3 release with write high
    {4'd3,  1'b1, 3'd4, 1'b1, 1'b1, 8'h00, 8'h00}, // R3 stays cleared
    {4'd1,  1'b1, 3'd4, 1'b0, 1'b1, 8'h10, 8'h11}, // R1
    {4'd6,  1'b1, 3'd2, 1'b0, 1'b1, 8'h04, 8'h44}  // R6 pair 2
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // R11 monitor: never two channels or two pairs at once
  always @(negedge clk) begin
    if (!rst) begin
      if (!$onehot0(sw)) ovl++;
      if (sw_p[3:0] != sw_p[7:4] || !$onehot0(sw_p[3:0])) ovl++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(4);
    chk("R12 reset single", sw, 8'h00);
    chk("R12 reset pair", sw_p, 8'h00);
    rst = 1'b0;
    // R10: not armed yet
    cyc(20);
    chk("R10 unarmed", sw, 8'h00);
    clr_n = 1'b0; cyc(2); clr_n = 1'b1;
    cyc(20);
    chk("R10 short pulse", sw, 8'h00);
    chk("R10 short pulse pair", sw_p, 8'h00);
    clr_n = 1'b0; cyc(5); clr_n = 1'b1;
    cyc(20);
    chk("R10 armed", sw, 8'h08);
    chk("R10 armed pair", sw_p, 8'h88);

    for (int i = 0; i < NV; i++) begin
      en    = VEC[i][21];
      addr  = VEC[i][20:18];
      wr_n  = VEC[i][17];
      clr_n = VEC[i][16];
      cyc(12);
      chk($sformatf("R%0d vec%0d", VEC[i][25:22], i), sw, VEC[i][15:8]);
      chk($sformatf("R%0d vec%0d pair", VEC[i][25:22], i), sw_p, VEC[i][7:0]);
    end

    // R7 exact switchover timing: from addr 2 to addr 5
    addr = 3'd5;
    for (int n = 1; n <= 7; n++) begin
      cyc(1);
      chk($sformatf("R7 step%0d", n), sw, (n == 1) ? 8'h04 : (n == 7) ? 8'h20 : 8'h00);
      chk($sformatf("R7 step%0d pair", n), sw_p, (n == 1) ? 8'h44 : (n == 7) ? 8'h22 : 8'h00);
    end

    // R8 restart: addr 3 then addr 6 two cycles later
    addr = 3'd3;
    cyc(2);
    addr = 3'd6;
    for (int n = 1; n <= 7; n++) begin
      cyc(1);
      chk($sformatf("R8 step%0d", n), sw, (n == 7) ? 8'h40 : 8'h00);
      chk($sformatf("R8 step%0d pair", n), sw_p, (n == 7) ? 8'h44 : 8'h00);
    end

    // R9 turn-off without dead interval
    en = 1'b0;
    cyc(1);
    chk("R9 one edge", sw, 8'h40);
    cyc(1);
    chk("R9 off", sw, 8'h00);
    chk("R9 off pair", sw_p, 8'h00);

    // R12 reset mid-run disarms
    en = 1'b1;
    cyc(12);
    chk("R1 back on", sw, 8'h40);
    rst = 1'b1;
    cyc(1);
    chk("R12 immediate", sw, 8'h00);
    rst = 1'b0;
    cyc(20);
    chk("R12 disarmed", sw, 8'h00);
    chk("R12 disarmed pair", sw_p, 8'h00);

    n_chk++;
    if (ovl != 0) begin
      n_bad++;
      $display("FAIL R11 overlap act=%0d exp=0", ovl);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule